// File: doc/BRIEF.md
# Serial/Parallel Delay-Setting Register

This block holds an 8-bit timing code for downstream delay logic. The code can be written in two ways, chosen by a mode pin. In parallel mode the eight pin inputs pass straight into the register while the latch enable is high, and they are held once it drops. In serial mode three of those same pins become a data input, a shift clock and a shift output. A separate shadow shift register takes bits most significant first, and the downstream code changes only when the latch enable falls.

The shift clock is an ordinary pin sampled by the system clock; its rising edges are found by comparing it with its value one cycle earlier. The shift output shows the shadow's top bit, so devices can be chained, and a read loop (output fed back to input) restores the contents after eight clocks. A one-cycle strobe marks each change of the active code.

Top module: `delay_set_reg`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the shadow and active registers, so `delay_val` reads 0 and `val_upd` reads 0 on the cycle after.
- R2: In parallel mode (`ser_mode` = 0) with `latch_en` = 1, `delay_val` equals `pin_bus`, one clock after it was sampled.
- R3: In parallel mode with `latch_en` = 0, `delay_val` and the shadow hold, whatever `pin_bus` does.
- R4: In serial mode (`ser_mode` = 1) with `latch_en` = 1, each rising edge of `pin_bus[1]` (the shift clock, detected as 1 now and 0 one clock earlier) shifts `pin_bus[2]` into bit 0 of the shadow, moving older bits toward bit 7.
- R5: In serial mode, `delay_val` does not change while `latch_en` is 1.
- R6: In serial mode, a falling edge of `latch_en` (1 one clock earlier, 0 now) copies the shadow into `delay_val`.
- R7: `ser_out` shows shadow bit 7 when `ser_mode` = 1 and `latch_en` = 1 and is 0 otherwise, so a shift presents the old contents most significant bit first, bit 7 visible before any shift edge.
- R8: With `ser_out` fed back to the data input, eight shift edges leave the shadow unchanged, and the following latch enable fall leaves `delay_val` unchanged with no strobe.
- R9: `val_upd` is 1 for exactly the cycle in which `delay_val` first shows a new value, and 0 otherwise.
- R10: In serial mode with `latch_en` = 0, shift clock edges do not alter the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode | input | 1 | 0 = parallel loading, 1 = serial loading |
| latch_en | input | 1 | Latch enable: follow/shift when 1, hold/activate when 0 |
| pin_bus | input | 8 | Parallel code; in serial mode bit 2 is data in and bit 1 is shift clock |
| ser_out | output | 1 | Serial shift output (shares the bit-0 pin in serial mode) |
| delay_val | output | 8 | Active timing code |
| val_upd | output | 1 | One-cycle strobe when the active code changes |

## Verification
The embedded assertions watch the per-cycle rules: reset clearing, the freeze of the active code during a serial load and during a closed parallel latch, the capture of the data pin into bit 0 on each detected shift edge, the shadow-to-active copy on a latch enable fall, and that the strobe appears only when the code truly changed. The bench's reference model is needed for the sequences: MSB-first ordering of a whole byte, the old contents leaving through the serial output in order, shift edges being ignored with the latch closed, and the loop-back read restoring the value with no strobe.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    LOAD_PARALLEL = 1'b0,
    LOAD_SERIAL   = 1'b1
  } load_mode_e;

  localparam int unsigned DSR_MIN_WIDTH = 3;
endpackage

// File: rtl/dsr_edge.sv
module dsr_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic hit
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = lvl & ~lvl_q;
    end else begin : g_fall
      assign hit = ~lvl & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/dsr_shadow.sv
module dsr_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         par_ld,
  input  logic [W-1:0] par_val,
  input  logic         shift_en,
  input  logic         sdin,
  output logic [W-1:0] word
);
  function automatic logic [W-1:0] push_lsb(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (par_ld)   word <= par_val;
    else if (shift_en) word <= push_lsb(word, sdin);
  end
endmodule

// File: rtl/dsr_active.sv
module dsr_active #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] val,
  output logic [W-1:0] q,
  output logic         upd
);
  function automatic logic differs(input logic [W-1:0] a, input logic [W-1:0] b);
    return |(a ^ b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      upd <= ld && differs(val, q);
      if (ld) q <= val;
    end
  end

  // R9
  upd_means_change_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> (q != $past(q)));
endmodule

// File: rtl/delay_set_reg.sv
module delay_set_reg #(
  parameter int unsigned W       = 8,
  parameter int unsigned SDI_POS = 2,
  parameter int unsigned SCK_POS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_mode,
  input  logic         latch_en,
  input  logic [W-1:0] pin_bus,
  output logic         ser_out,
  output logic [W-1:0] delay_val,
  output logic         val_upd
);
  import dsr_pkg::*;

  localparam int unsigned TOP = W - 1;

  load_mode_e   mode;
  logic         sck_rise;
  logic         le_fall;
  logic         par_ld;
  logic         shift_ev;
  logic         act_ld;
  logic [W-1:0] shadow_w;
  logic [W-1:0] act_src;

  assign mode     = load_mode_e'(ser_mode);
  assign par_ld   = (mode == LOAD_PARALLEL) && latch_en;
  assign shift_ev = (mode == LOAD_SERIAL) && latch_en && sck_rise;
  assign act_ld   = par_ld || ((mode == LOAD_SERIAL) && le_fall);
  assign act_src  = par_ld ? pin_bus : shadow_w;

  dsr_edge #(.RISING(1'b1)) u_sck_edge (
    .clk(clk), .rst(rst), .lvl(pin_bus[SCK_POS]), .hit(sck_rise)
  );

  dsr_edge #(.RISING(1'b0)) u_le_edge (
    .clk(clk), .rst(rst), .lvl(latch_en), .hit(le_fall)
  );

  dsr_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst(rst), .par_ld(par_ld), .par_val(pin_bus),
    .shift_en(shift_ev), .sdin(pin_bus[SDI_POS]), .word(shadow_w)
  );

  dsr_active #(.W(W)) u_active (
    .clk(clk), .rst(rst), .ld(act_ld), .val(act_src),
    .q(delay_val), .upd(val_upd)
  );

  assign ser_out = (mode == LOAD_SERIAL) && latch_en && shadow_w[TOP];

  initial begin
    if (W < DSR_MIN_WIDTH || SDI_POS >= W || SCK_POS >= W)
      $error("delay_set_reg: bad width or pin position");
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (delay_val == '0 && shadow_w == '0 && !val_upd));

  // R3
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_mode && !latch_en) |=> ($stable(delay_val) && $stable(shadow_w)));

  // R4
  shift_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && latch_en && sck_rise) |=> (shadow_w[0] == $past(pin_bus[SDI_POS])));

  // R5
  serial_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && latch_en) |=> $stable(delay_val));

  // R6
  activate_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && le_fall) |=> (delay_val == $past(shadow_w)));
endmodule

// File: tb/delay_set_reg_tb_top.sv
module delay_set_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b0;
  logic       latch_en = 1'b0;
  logic [7:0] pin_bus = 8'h00;
  logic       ser_out;
  logic [7:0] delay_val;
  logic       val_upd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  delay_set_reg dut_i (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .latch_en(latch_en),
    .pin_bus(pin_bus), .ser_out(ser_out), .delay_val(delay_val), .val_upd(val_upd)
  );

  // Behavioural reference: shadow kept as a bit queue, index 0 = MSB
  bit m_sh[$];
  int m_act = 0;
  bit m_upd = 0;
  bit m_sck_prev = 0;
  bit m_le_prev = 0;

  function automatic int sh_value();
    int v = 0;
    foreach (m_sh[i]) v = v * 2 + m_sh[i];
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) m_sh.push_back(1'b0);
  end

  always @(posedge clk) begin
    int nxt;
    if (rst) begin
      m_sh.delete();
      for (int i = 0; i < 8; i++) m_sh.push_back(1'b0);
      m_act = 0; m_upd = 0; m_sck_prev = 0; m_le_prev = 0;
    end else begin
      nxt = m_act;
      if (!ser_mode) begin
        if (latch_en) begin
          m_sh.delete();
          for (int i = 7; i >= 0; i--) m_sh.push_back(pin_bus[i]);
          nxt = pin_bus;
        end
      end else begin
        if (latch_en && pin_bus[1] && !m_sck_prev) begin
          void'(m_sh.pop_front());
          m_sh.push_back(pin_bus[2]);
        end
        if (m_le_prev && !latch_en) nxt = sh_value();
      end
      m_upd = (nxt != m_act);
      m_act = nxt;
      m_sck_prev = pin_bus[1];
      m_le_prev = latch_en;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      check(cur_req, "delay_val", delay_val, m_act);
      check("R9", "val_upd", val_upd, m_upd);
      check("R7", "ser_out", ser_out, (ser_mode && latch_en) ? m_sh[0] : 0);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic sbit(bit d);
    pin_bus[1] = 1'b0; pin_bus[2] = d; cyc();
    pin_bus[1] = 1'b1; cyc();
    pin_bus[1] = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_up();
    end
  end

  initial begin
    logic [7:0] pat;
    logic [7:0] old;
    cyc(); cyc(); cyc();
    check("R1", "delay_val after reset", delay_val, 0);
    check("R1", "val_upd after reset", val_upd, 0);
    rst = 1'b0;

    // parallel follow
    cur_req = "R2";
    latch_en = 1'b1; pin_bus = 8'hA5; cyc();
    check("R2", "parallel follow", delay_val, 8'hA5);
    check("R9", "strobe on change", val_upd, 1);
    pin_bus = 8'h5A; cyc();
    check("R2", "parallel follow second", delay_val, 8'h5A);
    cyc();
    check("R9", "strobe one cycle", val_upd, 0);

    // parallel freeze
    cur_req = "R3";
    latch_en = 1'b0; pin_bus = 8'h3C; cyc();
    pin_bus = 8'hFF; cyc();
    check("R3", "parallel hold", delay_val, 8'h5A);
    latch_en = 1'b1; pin_bus = 8'h3C; cyc();
    check("R2", "parallel reopen", delay_val, 8'h3C);
    latch_en = 1'b0; cyc();

    // serial load of 0x96, shadow starts at 0x3C
    cur_req = "R5";
    ser_mode = 1'b1; pin_bus = 8'h00; cyc();
    check("R7", "ser_out low while latch closed", ser_out, 0);
    latch_en = 1'b1; cyc();
    pat = 8'h96; old = 8'h3C;
    check("R7", "bit 7 before first edge", ser_out, old[7]);
    for (int i = 7; i >= 0; i--) begin
      sbit(pat[i]);
      if (i > 0) check("R7", "old bit shifted out", ser_out, old[i-1]);
      check("R5", "active frozen during shift", delay_val, 8'h3C);
    end
    check("R4", "msb-first shadow top bit", ser_out, 1);
    cur_req = "R6";
    latch_en = 1'b0; cyc();
    check("R6", "activate on fall", delay_val, 8'h96);
    check("R9", "strobe on activation", val_upd, 1);
    cyc();

    // shift edges with latch closed are ignored
    cur_req = "R10";
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    latch_en = 1'b1; cyc();
    check("R10", "shadow msb unchanged", ser_out, 1);
    latch_en = 1'b0; cyc();
    check("R10", "active after ignored edges", delay_val, 8'h96);
    check("R10", "no strobe", val_upd, 0);
    cyc();

    // loop-back read restores the value
    cur_req = "R8";
    latch_en = 1'b1; cyc();
    for (int i = 0; i < 8; i++) begin
      bit fb;
      fb = ser_out;
      check("R8", "read bit", fb, pat[7-i]);
      sbit(fb);
    end
    latch_en = 1'b0; cyc();
    check("R8", "value restored", delay_val, 8'h96);
    check("R8", "no strobe after restore", val_upd, 0);
    cyc();

    // second serial value, different pattern
    cur_req = "R4";
    latch_en = 1'b1; cyc();
    pat = 8'h4B;
    for (int i = 7; i >= 0; i--) sbit(pat[i]);
    latch_en = 1'b0; cyc();
    check("R4", "second serial value", delay_val, 8'h4B);
    cyc();

    // reset in the middle
    cur_req = "R1";
    rst = 1'b1; cyc(); cyc();
    check("R1", "mid reset clears", delay_val, 0);
    rst = 1'b0; ser_mode = 1'b1; latch_en = 1'b1; pin_bus = 8'h00; cyc();
    check("R1", "shadow cleared (ser_out)", ser_out, 0);
    latch_en = 1'b0; cyc(); cyc();
    finish_up();
  end
endmodule